// File: doc/BRIEF.md
# Ultra DMA Host Write-Burst Transmitter

This block is the host-side sender for a 16-bit data-out burst toward a storage device. Words arrive on an upstream valid/ready stream. Each accepted word is placed on the `dd` bus. After a setup interval, the block toggles `hstrobe` to deliver it. A rising transition and a falling transition each carry one word. The block spaces transitions to respect a minimum gap between any two edges and a longer minimum gap between two edges of the same direction. It also keeps `dd` steady for a hold interval after each edge.

Two sources can pause the flow. The first is local logic, through `pause_req`. A host pause only takes effect once at least one word has gone out. The second is the device, which raises the active-low ready line `dmardy_n`. That line passes through a flip-flop synchronizer. Strobe edges stop within a fixed number of system-clock cycles of it going high. During a pause, the strobe keeps its level, so the edge that resumes the flow has the opposite direction to the last one. Every limit is a parameter counted in system-clock cycles. A saturating counter of delivered words is exported.

Top module: `udma_wr_burst_tx`

## Requirements
- R1: Every `hstrobe` transition, rising or falling, delivers exactly one word. The value on `dd` at that transition is the next upstream word in acceptance order, and no word is lost or repeated across pauses.
- R2: Two consecutive `hstrobe` transitions are at least `T_CYC` clock cycles apart.
- R3: Two transitions of the same direction are at least `T_2CYC` cycles apart. In other words, any two adjacent gaps together reach `T_2CYC`.
- R4: After a transition, `dd` keeps its value for at least `T_DVH` cycles. A new word stays on `dd` for at least `T_SU` cycles before the transition that delivers it.
- R5: While `words_sent` is zero, `pause_req` has no effect. The first word is delivered even with `pause_req` held high.
- R6: When `pause_req` is high and at least one word has been delivered, no transition occurs and `hstrobe` keeps its level. After `pause_req` falls, the held word is delivered on an edge of the direction opposite to the last one.
- R7: Once `dmardy_n` has been sampled high on `SYNC_STAGES` consecutive clock edges, no transition occurs on the next edge or on any later edge while it stays high. The default allows no transition from the third rising edge after it is first sampled high. When `dmardy_n` returns low, delivery resumes.
- R8: `words_sent` increases by one on each transition and saturates at its all-ones value.
- R9: Reset is synchronous and active high. While reset is applied, `hstrobe` is 0, `dd` is 0 and `words_sent` is 0. After reset, `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Upstream word valid |
| s_data | input | DW | Upstream word |
| s_ready | output | 1 | Block can take a word this cycle |
| pause_req | input | 1 | Local request to withhold strobe edges |
| dmardy_n | input | 1 | Device ready, active low, asynchronous |
| dd | output | DW | Data bus toward the device |
| hstrobe | output | 1 | Strobe; each transition delivers one word |
| words_sent | output | CNT_W | Saturating count of delivered words |

## Verification
In a single cycle, a word can be due for its edge by spacing and setup while a pause input is also active. The test provokes this by raising `pause_req` with a word waiting, in two cases: right after reset, when the request must be ignored, and after one word, when it must hold the strobe. It also raises `dmardy_n` in the middle of a continuous stream, so that the synchronizer's latency competes with the pacing counters. It judges the outcome by how many edges still appear, by the strobe level that is held, and by the order and value of every word seen at each edge.

// File: rtl/udma_tx_pkg.sv
package udma_tx_pkg;
  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/udma_tx_sync.sv
module udma_tx_sync #(
  parameter int       STAGES  = 2,
  parameter bit       RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= {STAGES{RST_VAL}};
    end else begin
      sh[0] <= d;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/udma_tx_pacer.sv
module udma_tx_pacer
  import udma_tx_pkg::*;
#(
  parameter int T_CYC  = 3,
  parameter int T_2CYC = 8,
  parameter int T_DVH  = 1,
  parameter int T_SU   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic load,
  output logic space_ok,
  output logic hold_ok,
  output logic setup_ok
);
  localparam int SAT    = max2(max2(T_CYC, T_2CYC), max2(T_DVH, 1));
  localparam int GW     = $clog2(SAT + 1);
  localparam int SU_SAT = max2(T_SU, 1);
  localparam int SW     = $clog2(SU_SAT + 1);

  localparam logic [GW-1:0] G_MAX  = GW'(SAT);
  localparam logic [GW-1:0] G_CYC  = GW'(T_CYC);
  localparam logic [GW-1:0] G_DVH  = GW'(T_DVH);
  localparam logic [GW:0]   G_2CYC = (GW+1)'(T_2CYC);
  localparam logic [SW-1:0] S_MAX  = SW'(SU_SAT);
  localparam logic [SW-1:0] S_SU   = SW'(T_SU);

  logic [GW-1:0] gap_now;
  logic [GW-1:0] gap_prev;
  logic [SW-1:0] su_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_now  <= G_MAX;
      gap_prev <= G_MAX;
      su_cnt   <= '0;
    end else begin
      if (fire) begin
        gap_prev <= gap_now;
        gap_now  <= GW'(1);
      end else if (gap_now != G_MAX) begin
        gap_now <= gap_now + 1'b1;
      end
      if (load) su_cnt <= SW'(1);
      else if (su_cnt != S_MAX) su_cnt <= su_cnt + 1'b1;
    end
  end

  always_comb begin
    space_ok = (gap_now >= G_CYC) &&
               (({1'b0, gap_now} + {1'b0, gap_prev}) >= G_2CYC);
    hold_ok  = (gap_now >= G_DVH);
    setup_ok = (su_cnt >= S_SU);
  end
endmodule

// File: rtl/udma_tx_wordreg.sv
module udma_tx_wordreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          fire,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      full <= 1'b0;
    end else if (load) begin
      dout <= din;
      full <= 1'b1;
    end else if (fire) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/udma_wr_burst_tx.sv
module udma_wr_burst_tx #(
  parameter int DW          = 16,
  parameter int CNT_W       = 16,
  parameter int T_CYC       = 3,
  parameter int T_2CYC      = 8,
  parameter int T_DVH       = 1,
  parameter int T_SU        = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic [DW-1:0]    s_data,
  output logic             s_ready,
  input  logic             pause_req,
  input  logic             dmardy_n,
  output logic [DW-1:0]    dd,
  output logic             hstrobe,
  output logic [CNT_W-1:0] words_sent
);
  logic rdy_n_sync, dev_rdy;
  logic space_ok, hold_ok, setup_ok;
  logic full, load, fire, host_hold;

  udma_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk), .rst (rst), .d (dmardy_n), .q (rdy_n_sync)
  );

  udma_tx_pacer #(.T_CYC(T_CYC), .T_2CYC(T_2CYC), .T_DVH(T_DVH), .T_SU(T_SU)) u_pacer (
    .clk (clk), .rst (rst), .fire (fire), .load (load),
    .space_ok (space_ok), .hold_ok (hold_ok), .setup_ok (setup_ok)
  );

  udma_tx_wordreg #(.DW(DW)) u_word (
    .clk (clk), .rst (rst), .load (load), .fire (fire),
    .din (s_data), .dout (dd), .full (full)
  );

  always_comb begin
    dev_rdy   = ~rdy_n_sync;
    host_hold = pause_req && (words_sent != '0);
    s_ready   = ~full && hold_ok;
    load      = s_valid && s_ready;
    fire      = full && setup_ok && space_ok && dev_rdy && ~host_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hstrobe    <= 1'b0;
      words_sent <= '0;
    end else if (fire) begin
      hstrobe <= ~hstrobe;
      if (words_sent != '1) words_sent <= words_sent + 1'b1;
    end
  end
endmodule

// File: rtl/udma_wr_burst_tx_chk.sv
module udma_wr_burst_tx_chk #(
  parameter int DW          = 16,
  parameter int CNT_W       = 16,
  parameter int T_CYC       = 3,
  parameter int T_2CYC      = 8,
  parameter int T_DVH       = 1,
  parameter int T_SU        = 1,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             pause_req,
  input logic             dmardy_n,
  input logic [DW-1:0]    dd,
  input logic             hstrobe,
  input logic [CNT_W-1:0] words_sent
);
  localparam int LIM = 4096;

  logic             hs_q;
  logic [DW-1:0]    dd_q;
  logic [CNT_W-1:0] ws_q;
  int               since_edge, prev_gap, since_dd, hi_run;
  logic [1:0]       n_edges;
  logic             tgl, ddc;

  assign tgl = (hstrobe != hs_q);
  assign ddc = (dd != dd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0; dd_q <= '0; ws_q <= '0;
      since_edge <= 0; prev_gap <= 0; since_dd <= 0; hi_run <= 0;
      n_edges <= '0;
    end else begin
      hs_q <= hstrobe; dd_q <= dd; ws_q <= words_sent;
      if (tgl) begin
        prev_gap   <= since_edge;
        since_edge <= 1;
        if (n_edges != 2'd2) n_edges <= n_edges + 1'b1;
      end else if (since_edge < LIM) begin
        since_edge <= since_edge + 1;
      end
      if (ddc) since_dd <= 1;
      else if (since_dd < LIM) since_dd <= since_dd + 1;
      if (!dmardy_n) hi_run <= 0;
      else if (hi_run < LIM) hi_run <= hi_run + 1;
    end
  end

  AST_EDGE_GAP:  assert property (@(posedge clk) disable iff (rst)
    (tgl && n_edges != 2'd0) |-> since_edge >= T_CYC);                  // R2
  AST_SAME_POL:  assert property (@(posedge clk) disable iff (rst)
    (tgl && n_edges == 2'd2) |-> (prev_gap + since_edge) >= T_2CYC);    // R3
  AST_DD_HOLD:   assert property (@(posedge clk) disable iff (rst)
    (ddc && n_edges != 2'd0) |-> since_edge >= T_DVH);                  // R4
  AST_DD_SETUP:  assert property (@(posedge clk) disable iff (rst)
    tgl |-> since_dd >= T_SU);                                          // R4
  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pause_req && words_sent != '0) |=> !tgl);                          // R6
  AST_DEV_STOP:  assert property (@(posedge clk) disable iff (rst)
    (dmardy_n && hi_run >= SYNC_STAGES) |=> !tgl);                      // R7
  AST_CNT_STEP:  assert property (@(posedge clk) disable iff (rst)
    (tgl && ws_q != '1) |-> words_sent == ws_q + 1'b1);                 // R8
  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (hstrobe == 1'b0 && words_sent == '0 && dd == '0));         // R9
endmodule

bind udma_wr_burst_tx udma_wr_burst_tx_chk #(
  .DW(DW), .CNT_W(CNT_W), .T_CYC(T_CYC), .T_2CYC(T_2CYC),
  .T_DVH(T_DVH), .T_SU(T_SU), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .pause_req(pause_req), .dmardy_n(dmardy_n),
  .dd(dd), .hstrobe(hstrobe), .words_sent(words_sent)
);

// File: tb/udma_wr_burst_tx_tb.sv
module udma_wr_burst_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, CNT_W = 4;
  localparam int T_CYC = 3, T_2CYC = 8, T_DVH = 1, T_SU = 1, STAGES = 2;
  localparam int NV = 12;
  localparam logic [15:0] VEC_W [NV] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444,
    16'h5A5A, 16'hA5A5, 16'h0F0F, 16'hF0F0, 16'h1234, 16'h8001, 16'h7FFE, 16'hC3C3};
  localparam int VEC_IDLE [NV] = '{0, 0, 0, 4, 0, 1, 7, 0, 0, 2, 0, 9};

  logic clk = 1'b0, rst = 1'b1;
  logic s_valid = 1'b0, pause_req = 1'b0, dmardy_n = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, hstrobe;
  logic [DW-1:0] dd;
  logic [CNT_W-1:0] words_sent;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] exp_q [64];
  int n_exp = 0, n_edges = 0;
  int cyc = 0, last_edge = 0, prev_gap = 0, last_dd = 0;
  logic hs_p = 1'b0;
  logic [DW-1:0] dd_p = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udma_wr_burst_tx #(.DW(DW), .CNT_W(CNT_W), .T_CYC(T_CYC), .T_2CYC(T_2CYC),
    .T_DVH(T_DVH), .T_SU(T_SU), .SYNC_STAGES(STAGES)) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .pause_req(pause_req), .dmardy_n(dmardy_n), .dd(dd), .hstrobe(hstrobe),
    .words_sent(words_sent));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, input int idle);
    repeat (idle) @(negedge clk);
    exp_q[n_exp] = d;
    n_exp++;
    s_data  = d;
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // edge monitor: R1 order/value, R2/R3 spacing, R4 hold and setup
  always @(negedge clk) begin
    if (rst) begin
      hs_p = hstrobe; dd_p = dd; n_edges = 0;
    end else begin
      if (dd !== dd_p) begin
        if (n_edges > 0) chk(cyc - last_edge >= T_DVH, "R4 hold", cyc - last_edge, T_DVH);
        last_dd = cyc;
        dd_p = dd;
      end
      if (hstrobe !== hs_p) begin
        chk(dd === exp_q[n_edges], "R1 word", int'(dd), int'(exp_q[n_edges]));
        chk(cyc - last_dd >= T_SU, "R4 setup", cyc - last_dd, T_SU);
        if (n_edges > 0) chk(cyc - last_edge >= T_CYC, "R2 gap", cyc - last_edge, T_CYC);
        if (n_edges > 1) chk(cyc - last_edge + prev_gap >= T_2CYC, "R3 same-pol",
                             cyc - last_edge + prev_gap, T_2CYC);
        prev_gap = cyc - last_edge;
        last_edge = cyc;
        n_edges++;
        hs_p = hstrobe;
      end
    end
    cyc++;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic held;
    int base;
    repeat (3) @(negedge clk);
    chk(hstrobe == 1'b0, "R9 hstrobe", hstrobe, 0);
    chk(dd == '0, "R9 dd", int'(dd), 0);
    chk(words_sent == '0, "R9 count", int'(words_sent), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(s_ready == 1'b1, "R9 s_ready", s_ready, 1);

    // R5: pause ignored before the first word
    pause_req = 1'b1;
    push(16'hA001, 0);
    repeat (8) @(negedge clk);
    chk(words_sent == 1, "R5 first word", int'(words_sent), 1);
    chk(hstrobe == 1'b1, "R5 level", hstrobe, 1);
    // R6: pause holds level after one word
    push(16'hB002, 0);
    repeat (20) @(negedge clk);
    chk(words_sent == 1, "R6 held count", int'(words_sent), 1);
    chk(hstrobe == 1'b1, "R6 held level", hstrobe, 1);
    pause_req = 1'b0;
    repeat (8) @(negedge clk);
    chk(words_sent == 2, "R6 resume count", int'(words_sent), 2);
    chk(hstrobe == 1'b0, "R6 opposite edge", hstrobe, 0);

    // vector table: stream with varied upstream gaps
    for (int i = 0; i < NV; i++) push(VEC_W[i], VEC_IDLE[i]);
    repeat (12) @(negedge clk);
    chk(n_edges == 2 + NV, "R1 all delivered", n_edges, 2 + NV);
    chk(words_sent == 14, "R8 count", int'(words_sent), 14);

    // R7: device stops the stream mid-burst
    base = n_edges;
    fork
      begin
        for (int i = 0; i < 6; i++) push(16'hD000 + 16'(i * 3 + 1), 0);
      end
      begin
        while (n_edges < base + 2) @(negedge clk);
        dmardy_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        held = hstrobe;
        base = n_edges;
        repeat (20) begin
          @(negedge clk);
          chk(hstrobe == held, "R7 no edge while not ready", hstrobe, held);
        end
        chk(n_edges <= 2 + NV + 6, "R7 count bound", n_edges, 2 + NV + 6);
        dmardy_n = 1'b0;
      end
    join
    repeat (40) @(negedge clk);
    chk(n_edges == 2 + NV + 6, "R7 resume all", n_edges, 2 + NV + 6);
    chk(words_sent == 15, "R8 saturate", int'(words_sent), 15);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule